// File: doc/BRIEF.md
# Ring pulse-train detector

This block watches one raw ring-indicator line and decides whether a real ring burst is present or only noise or a slow disturbance. The line is first brought into the clock domain through a synchronizer chain, and only its falling transitions count as activity. Time is cut into fixed slots, counted from reset. For each slot the block notes whether at least one falling transition occurred. It then checks the sequence of busy and quiet slots.

A detection needs a quiet slot followed by three busy slots in a row. With slots of one 16 Hz period, this passes any train faster than 16 Hz. It rejects trains slower than 10 Hz, because such a train leaves every second or third slot quiet. Rates in between may go either way. On detection the block raises a one-cycle pulse and sets a sticky status bit. Software clears the status bit with a write-one strobe.

Top module: `ring_train_detect`

## Requirements
- R1: The ring line is synchronized, and only a high-to-low transition marks a slot busy. A level held low across several slots marks only the slot in which it fell.
- R2: A slot lasts SLOT_CYCLES clock cycles. The first slot begins in the first cycle after reset is released, and each slot follows the previous one with no gap.
- R3: A detection occurs at the end of the RUN_SLOTS-th (default 3) busy slot of an unbroken run of busy slots, provided the slot just before the run was quiet. Patterns of one or two busy slots between quiet slots never detect.
- R4: After reset no quiet slot has yet been seen. Busy slots before the first quiet slot never contribute to a detection.
- R5: After a detection, further busy slots do not detect again until at least one quiet slot has passed. A following quiet slot and a new run of three busy slots detect again.
- R6: Several falling transitions within one slot count the same as one. A transition that reaches the edge detector in the last cycle of a slot belongs to that slot.
- R7: `det_pulse_o` is high for exactly one cycle: the first cycle of the slot after the one that completed the pattern, that is cycle k*SLOT_CYCLES after reset release.
- R8: `det_status_o` rises together with `det_pulse_o` and stays high until a cycle with `clr_i` high. It is low in the next cycle unless a detection happens at that same edge, in which case it stays high.
- R9: With `rst` high, both outputs read 0 from the second clock edge on, and the pattern history is cleared.
- R10: Two detection pulses, or reset and the first pulse, are at least (RUN_SLOTS+1)*SLOT_CYCLES cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_i | input | 1 | Raw ring-indicator line, asynchronous |
| clr_i | input | 1 | Write-one strobe that clears the status bit |
| det_pulse_o | output | 1 | One-cycle detection pulse |
| det_status_o | output | 1 | Sticky detection status |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that SLOT_CYCLES is at least two, so that a pulse cannot repeat in the next cycle. They make no assumption about `ring_i`, which may change at any time. The stimulus holds reset for two edges and uses 20-cycle slots. It changes the ring line and the clear strobe only at falling clock edges, so that each transition lands in a known slot. Each test starts from a fresh reset so that slot boundaries are known.

// File: rtl/ring_det_pkg.sv
package ring_det_pkg;

  // Tracker phase: waiting for a quiet slot, or counting busy slots after one
  typedef enum logic [0:0] {
    TRK_WAIT_QUIET = 1'b0,
    TRK_COUNTING   = 1'b1
  } trk_phase_e;

endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_i,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= ring_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  // Reset to 0 so that an idle-high line at release gives no spurious fall
  assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/ring_slot_timer.sv
module ring_slot_timer #(
  parameter int SLOT_CYCLES = 15_625_000
) (
  input  logic clk,
  input  logic rst,
  output logic slot_end_o
);

  localparam int CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign slot_end_o = (cnt_q == LAST);

endmodule

// File: rtl/ring_slot_tracker.sv
module ring_slot_tracker
  import ring_det_pkg::*;
#(
  parameter int RUN_SLOTS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic slot_end_i,
  output logic det_o
);

  localparam int RUN_W = $clog2(RUN_SLOTS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_SLOTS - 1);

  trk_phase_e       phase_q;
  logic [RUN_W-1:0] run_q;
  logic             hit_q;
  logic             slot_busy;

  // An edge in the slot's final cycle still belongs to that slot
  assign slot_busy = hit_q | fall_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      phase_q <= TRK_WAIT_QUIET;
      run_q   <= '0;
    end else if (slot_end_i) begin
      hit_q <= 1'b0;
      if (!slot_busy) begin
        phase_q <= TRK_COUNTING;
        run_q   <= '0;
      end else if (phase_q == TRK_COUNTING) begin
        if (run_q == RUN_LAST) begin
          phase_q <= TRK_WAIT_QUIET;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end else if (fall_i) begin
      hit_q <= 1'b1;
    end
  end

  assign det_o = slot_end_i & slot_busy & (phase_q == TRK_COUNTING) & (run_q == RUN_LAST);

endmodule

// File: rtl/ring_train_detect.sv
module ring_train_detect #(
  parameter int SLOT_CYCLES = 15_625_000,
  parameter int RUN_SLOTS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_i,
  input  logic clr_i,
  output logic det_pulse_o,
  output logic det_status_o
);

  logic fall;
  logic slot_end;
  logic det;

  ring_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .ring_i (ring_i),
    .fall_o (fall)
  );

  ring_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .slot_end_o (slot_end)
  );

  ring_slot_tracker #(.RUN_SLOTS(RUN_SLOTS)) u_track (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (fall),
    .slot_end_i (slot_end),
    .det_o      (det)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      det_pulse_o  <= 1'b0;
      det_status_o <= 1'b0;
    end else begin
      det_pulse_o <= det;
      if (det)        det_status_o <= 1'b1;
      else if (clr_i) det_status_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ring_det_checks.sv
module ring_det_checks #(
  parameter int SLOT_CYCLES = 15_625_000,
  parameter int RUN_SLOTS   = 3
) (
  input logic clk,
  input logic rst,
  input logic clr_i,
  input logic det_pulse_o,
  input logic det_status_o
);

  localparam logic [31:0] MIN_GAP = 32'((RUN_SLOTS + 1) * SLOT_CYCLES);

  logic [31:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                 gap_q <= '0;
    else if (det_pulse_o)    gap_q <= 32'd1;
    else if (gap_q != '1)    gap_q <= gap_q + 32'd1;
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    det_pulse_o |=> !det_pulse_o);

  assert_pulse_sets_status_R8: assert property (@(posedge clk) disable iff (rst)
    det_pulse_o |-> det_status_o);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_i) && !det_pulse_o) |-> !det_status_o);

  assert_status_holds_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(det_status_o) && !$past(clr_i)) |-> det_status_o);

  assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(det_status_o) && !det_pulse_o) |-> !det_status_o);

  assert_min_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    det_pulse_o |-> (gap_q >= MIN_GAP));

endmodule

bind ring_train_detect ring_det_checks #(
  .SLOT_CYCLES (SLOT_CYCLES),
  .RUN_SLOTS   (RUN_SLOTS)
) u_checks (
  .clk          (clk),
  .rst          (rst),
  .clr_i        (clr_i),
  .det_pulse_o  (det_pulse_o),
  .det_status_o (det_status_o)
);

// File: tb/tb_ring_train_detect.sv
module tb_ring_train_detect;

  localparam int S      = 20;
  localparam int NSLOTS = 10;
  localparam int NVEC   = 11;

  // {mode[1:0], busy-slot pattern[9:0], expected detect slots[9:0]}
  // mode 0: one short low pulse early in slot; 1: low only in last 3 cycles;
  // mode 2: toggling every 2 cycles; 3: line held low for the whole slot
  localparam logic [21:0] VECS [NVEC] = '{
    {2'd0, 10'h3FF, 10'h000},
    {2'd0, 10'h00E, 10'h008},
    {2'd0, 10'h3FE, 10'h008},
    {2'd0, 10'h076, 10'h040},
    {2'd0, 10'h2AA, 10'h000},
    {2'd0, 10'h0EE, 10'h088},
    {2'd0, 10'h01D, 10'h010},
    {2'd1, 10'h00E, 10'h008},
    {2'd2, 10'h00E, 10'h008},
    {2'd3, 10'h00E, 10'h000},
    {2'd0, 10'h1B6, 10'h000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_i = 1'b1;
  logic clr_i = 1'b0;
  logic det_pulse_o;
  logic det_status_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic st_log [0:511];
  logic pl_log [0:511];

  always #2 clk = ~clk;

  ring_train_detect #(.SLOT_CYCLES(S), .RUN_SLOTS(3), .SYNC_STAGES(2)) dut (
    .clk          (clk),
    .rst          (rst),
    .ring_i       (ring_i),
    .clr_i        (clr_i),
    .det_pulse_o  (det_pulse_o),
    .det_status_o (det_status_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0, 6:    return "R4";
      2, 5:    return "R5";
      7, 8:    return "R6";
      9:       return "R1";
      default: return "R3";
    endcase
  endfunction

  function automatic logic ring_lvl(input logic [1:0] mode, input logic [9:0] pat, input int t);
    int k   = t / S;
    int off = t % S;
    if (k >= NSLOTS || !pat[k]) return 1'b1;
    case (mode)
      2'd0:    return !(off >= 4 && off < 12);
      2'd1:    return !(off >= S - 3);
      2'd2:    return !(off % 4 >= 2);
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_reset();
    ring_i = 1'b1;
    clr_i  = 1'b0;
    rst    = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Starts at interval 0 after reset release; logs outputs per cycle
  task automatic run_seq(input logic [1:0] mode, input logic [9:0] pat, input int clr_at,
                         output logic [9:0] obs, output int misaligned);
    obs = '0;
    misaligned = 0;
    do_reset();
    for (int t = 0; t <= NSLOTS * S; t++) begin
      ring_i = ring_lvl(mode, pat, t);
      clr_i  = (t == clr_at);
      st_log[t] = det_status_o;
      pl_log[t] = det_pulse_o;
      if (det_pulse_o && t > 0) begin
        if (t % S != 0) misaligned++;
        else obs[t / S - 1] = 1'b1;
      end
      @(negedge clk);
    end
    ring_i = 1'b1;
    clr_i  = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 100_000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [9:0] obs;
    int mis;

    // R9: outputs during reset
    @(negedge clk);
    @(negedge clk);
    check(det_status_o == 1'b0 && det_pulse_o == 1'b0, "R9 outputs in reset",
          {det_status_o, det_pulse_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_seq(VECS[i][21:20], VECS[i][19:10], -1, obs, mis);
      check(obs == VECS[i][9:0], vec_req(i), int'(obs), int'(VECS[i][9:0]));
      check(mis == 0, "R7 pulse alignment", mis, 0);
    end

    // R2/R7/R8: exact pulse cycle, sticky status, write-one clear
    run_seq(2'd0, 10'h00E, 6 * S, obs, mis);
    check(st_log[0] == 1'b0 && pl_log[0] == 1'b0, "R9 first cycle after reset",
          {st_log[0], pl_log[0]}, 0);
    check(pl_log[4*S-1] == 1'b0 && st_log[4*S-1] == 1'b0, "R2 nothing before slot end",
          {st_log[4*S-1], pl_log[4*S-1]}, 0);
    check(pl_log[4*S] == 1'b1, "R7 pulse at cycle 4*S", pl_log[4*S], 1);
    check(pl_log[4*S+1] == 1'b0, "R7 pulse one cycle", pl_log[4*S+1], 0);
    check(st_log[4*S] == 1'b1, "R8 status set with pulse", st_log[4*S], 1);
    check(st_log[6*S] == 1'b1, "R8 status sticky", st_log[6*S], 1);
    check(st_log[6*S+1] == 1'b0, "R8 status cleared", st_log[6*S+1], 0);

    // R8: clear in the same cycle as a detection loses
    run_seq(2'd0, 10'h00E, 4 * S - 1, obs, mis);
    check(st_log[4*S] == 1'b1, "R8 set wins over clear", st_log[4*S], 1);
    check(st_log[4*S+1] == 1'b1, "R8 still set after colliding clear", st_log[4*S+1], 1);

    // R9: reset after a detection clears status
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(det_status_o == 1'b0, "R9 reset clears status", det_status_o, 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule